// File: doc/BRIEF.md
# NAND Flash Access Stage Sequencer

This block runs one NAND flash access as a fixed chain of optional stages: an opening command byte, a run of address bytes, a closing command byte, and a data phase of whole sectors. A 32-bit configuration word selects the stages that run, how many address bytes are sent, whether the data phase reads or writes, and how many sectors are moved. The block drives the flash latch strobes (command latch, address latch, active-low write strobe and active-low read strobe) and an 8-bit I/O bus with an output enable. It holds off the data phase until the flash reports ready, and it gives a one-cycle completion pulse.

Two access modes exist. In command mode the data phase always moves exactly one sector, and the sector count held in the configuration word is set to 1 at start. In sector mode the data phase repeats back to back for the programmed number of sectors. The count goes down by one at the end of each sector and the access ends when it reaches zero. The caller holds the two command codes, the address word and the write data stable while the block is busy. Read bytes come out on a data port with a one-cycle valid flag. Write bytes are taken from an input port, and each taken byte is marked by a one-cycle take flag.

Top module: `nandSeqTop`

## Requirements
- R1: After reset the configuration word reads as zero, the write and read strobes are high, the command and address latch strobes are low, the output enable is low, and busy and done are low.
- R2: The configuration word uses bit 0 for opening command enable, bit 1 for address stage enable, bits 3:2 for the address byte count, bit 4 for closing command enable, bit 5 for data direction (0 read, 1 write) and bits 31:16 for the sector count. All other bits read as 0 whatever is written. A configuration write is ignored while busy is high.
- R3: Enabled stages run in the order opening command, address, closing command, data. The first enabled stage begins in the cycle right after start is accepted, and each stage follows the one before it with no idle cycle.
- R4: An address count code of 0, 1, 2 or 3 sends 1, 2, 3 or 4 bytes of the address word, least significant byte first. The address stage is left out when its enable bit is 0.
- R5: Each command or address byte takes two cycles: the write strobe is low in the first and high in the second. The command latch strobe is high for command bytes, the address latch strobe is high for address bytes, and the byte is on the I/O bus with the output enable high.
- R6: The block waits for the ready input after the closing command stage and before every sector in sector mode. No data strobe is issued while ready is low.
- R7: A sector is SECTOR_BYTES bytes, one byte per two-cycle strobe. When reading, the read strobe pulses and the byte sampled at the end of its low cycle appears on the read data port with the valid flag in the next cycle. When writing, the write strobe pulses with the write data on the bus and the output enable high, and the take flag marks the high cycle.
- R8: In sector mode the sector count goes down by one at the end of each sector and the access ends after the sector that brings it to 0. A count of 0 gives no data phase.
- R9: In command mode the sector count field becomes 1 when start is accepted, and exactly one sector is moved.
- R10: Busy is high from the cycle after start is accepted up to and including the one-cycle done pulse. A start pulse is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration word write enable |
| cfgWrData | input | 32 | Configuration word write value |
| cfgRdData | output | 32 | Configuration word read value |
| sectorMode | input | 1 | 1 selects sector mode, 0 selects command mode; sampled at start |
| start | input | 1 | Start pulse |
| cmd1Code | input | 8 | Opening command byte |
| cmd2Code | input | 8 | Closing command byte |
| addrWord | input | 32 | Address bytes, least significant sent first |
| wrData | input | 8 | Byte to write in the data phase |
| wrTake | output | 1 | Write byte consumed |
| rdData | output | 8 | Byte read in the data phase |
| rdValid | output | 1 | rdData valid |
| flashReady | input | 1 | Flash ready (1) or busy (0) |
| ioIn | input | 8 | Flash I/O bus input |
| ioOut | output | 8 | Flash I/O bus output |
| ioOe | output | 1 | Flash I/O bus output enable |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| weN | output | 1 | Active-low write strobe |
| reN | output | 1 | Active-low read strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the strobe pairs stay well formed. The two latch strobes are never high together, the write and read strobes are never low together, and each strobe's low cycle is followed by a high cycle. The output enable is high under a latch strobe, done lasts one cycle and falls inside busy, busy holds until done, and the reserved configuration bits stay zero. Only the bench scenarios show stage order and skipping, the number and order of address bytes, the wait on ready, read data capture, the count going down over several sectors, the count being set to 1 in command mode, and start or configuration writes being ignored while busy. The bench's cycle model checks these against the ports.

// File: rtl/nandSeqPkg.sv
package nandSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2, ST_WAIT, ST_DATA, ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       selCmd1;
    logic       selCmd2;
    logic       selAddr;
    logic       selWrite;
    logic       capture;
    logic       forceOne;
    logic       decCount;
    logic [1:0] addrIdx;
  } pathStrobe_t;

  localparam int CNT_W       = 16;
  localparam int CFG_W       = 32;
  localparam int B_CMD1      = 0;
  localparam int B_ADDR_EN   = 1;
  localparam int B_ACNT      = 2;
  localparam int B_CMD2      = 4;
  localparam int B_DIR       = 5;
  localparam int B_CNT       = CFG_W - CNT_W;
  localparam logic [CFG_W-1:0] CFG_MASK = {{CNT_W{1'b1}}, {(B_CNT-6){1'b0}}, 6'h3F};

endpackage

// File: rtl/nandSeqPath.sv
module nandSeqPath
  import nandSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             busy,
  input  pathStrobe_t      strobe,
  input  logic [7:0]       cmd1Code,
  input  logic [7:0]       cmd2Code,
  input  logic [31:0]      addrWord,
  input  logic [7:0]       wrData,
  input  logic [7:0]       ioIn,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             cmd1En,
  output logic             addrEn,
  output logic [1:0]       addrCnt,
  output logic             cmd2En,
  output logic             dirWrite,
  output logic             countZero,
  output logic             countOne,
  output logic [7:0]       ioOut,
  output logic [7:0]       rdData,
  output logic             rdValid
);

  logic [CFG_W-1:0] cfgReg;
  logic [CNT_W-1:0] secCount;
  logic [7:0]       addrLane [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign addrLane[g] = addrWord[8*g +: 8];
  end

  assign secCount  = cfgReg[B_CNT +: CNT_W];
  assign cmd1En    = cfgReg[B_CMD1];
  assign addrEn    = cfgReg[B_ADDR_EN];
  assign addrCnt   = cfgReg[B_ACNT +: 2];
  assign cmd2En    = cfgReg[B_CMD2];
  assign dirWrite  = cfgReg[B_DIR];
  assign countZero = (secCount == '0);
  assign countOne  = (secCount == CNT_W'(1));
  assign cfgRdData = cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else begin
      if (cfgWrEn && !busy) cfgReg <= cfgWrData & CFG_MASK;
      if (strobe.forceOne) cfgReg[B_CNT +: CNT_W] <= CNT_W'(1);
      else if (strobe.decCount) cfgReg[B_CNT +: CNT_W] <= secCount - CNT_W'(1);
    end
  end

  always_comb begin
    ioOut = '0;
    if (strobe.selCmd1)       ioOut = cmd1Code;
    else if (strobe.selCmd2)  ioOut = cmd2Code;
    else if (strobe.selAddr)  ioOut = addrLane[strobe.addrIdx];
    else if (strobe.selWrite) ioOut = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= ioIn;
    end
  end

endmodule

// File: rtl/nandSeqCtrl.sv
module nandSeqCtrl
  import nandSeqPkg::*;
#(
  parameter int SECTOR_BYTES = 512
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        sectorMode,
  input  logic        flashReady,
  input  logic        cmd1En,
  input  logic        addrEn,
  input  logic [1:0]  addrCnt,
  input  logic        cmd2En,
  input  logic        dirWrite,
  input  logic        countZero,
  input  logic        countOne,
  output pathStrobe_t strobe,
  output logic        cle,
  output logic        ale,
  output logic        weN,
  output logic        reN,
  output logic        ioOe,
  output logic        wrTake,
  output logic        busy,
  output logic        done
);

  localparam int BYTE_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1;
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(SECTOR_BYTES - 1);

  seqState_e         state;
  logic              phase;
  logic              modeLat;
  logic [1:0]        addrIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic              inCmd, inData, lastByte;

  function automatic seqState_e enterData(input logic viaCmd2, input logic modeS,
                                          input logic noSectors);
    if (modeS && noSectors)  return ST_DONE;
    if (viaCmd2 || modeS)    return ST_WAIT;
    return ST_DATA;
  endfunction

  function automatic seqState_e afterAddr(input logic c2, input logic modeS,
                                          input logic noSectors);
    if (c2) return ST_CMD2;
    return enterData(1'b0, modeS, noSectors);
  endfunction

  assign lastByte = (byteIdx == LAST_BYTE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      modeLat <= 1'b0;
      addrIdx <= '0;
      byteIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase <= 1'b0;
          if (start) begin
            modeLat <= sectorMode;
            addrIdx <= '0;
            byteIdx <= '0;
            if (cmd1En)      state <= ST_CMD1;
            else if (addrEn) state <= ST_ADDR;
            else             state <= afterAddr(cmd2En, sectorMode, countZero);
          end
        end
        ST_CMD1: begin
          phase <= ~phase;
          if (phase) state <= addrEn ? ST_ADDR : afterAddr(cmd2En, modeLat, countZero);
        end
        ST_ADDR: begin
          phase <= ~phase;
          if (phase) begin
            if (addrIdx == addrCnt) state <= afterAddr(cmd2En, modeLat, countZero);
            else                    addrIdx <= addrIdx + 2'd1;
          end
        end
        ST_CMD2: begin
          phase <= ~phase;
          if (phase) state <= enterData(1'b1, modeLat, countZero);
        end
        ST_WAIT: begin
          if (flashReady) state <= ST_DATA;
        end
        ST_DATA: begin
          phase <= ~phase;
          if (phase) begin
            if (lastByte) begin
              byteIdx <= '0;
              state   <= countOne ? ST_DONE : ST_WAIT;
            end else begin
              byteIdx <= byteIdx + BYTE_W'(1);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inCmd  = (state == ST_CMD1) || (state == ST_CMD2);
  assign inData = (state == ST_DATA);

  assign cle    = inCmd;
  assign ale    = (state == ST_ADDR);
  assign ioOe   = inCmd || ale || (inData && dirWrite);
  assign weN    = !(ioOe && !phase);
  assign reN    = !(inData && !dirWrite && !phase);
  assign wrTake = inData && dirWrite && phase;
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);

  always_comb begin
    strobe          = '0;
    strobe.selCmd1  = (state == ST_CMD1);
    strobe.selCmd2  = (state == ST_CMD2);
    strobe.selAddr  = ale;
    strobe.selWrite = inData && dirWrite;
    strobe.capture  = inData && !dirWrite && !phase;
    strobe.forceOne = (state == ST_IDLE) && start && !sectorMode;
    strobe.decCount = inData && phase && lastByte;
    strobe.addrIdx  = addrIdx;
  end

endmodule

// File: rtl/nandSeqTop.sv
module nandSeqTop
  import nandSeqPkg::*;
#(
  parameter int SECTOR_BYTES = 512
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        sectorMode,
  input  logic        start,
  input  logic [7:0]  cmd1Code,
  input  logic [7:0]  cmd2Code,
  input  logic [31:0] addrWord,
  input  logic [7:0]  wrData,
  output logic        wrTake,
  output logic [7:0]  rdData,
  output logic        rdValid,
  input  logic        flashReady,
  input  logic [7:0]  ioIn,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  output logic        cle,
  output logic        ale,
  output logic        weN,
  output logic        reN,
  output logic        busy,
  output logic        done
);

  pathStrobe_t strobe;
  logic        cmd1En, addrEn, cmd2En, dirWrite, countZero, countOne;
  logic [1:0]  addrCnt;

  nandSeqCtrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sectorMode(sectorMode),
    .flashReady(flashReady), .cmd1En(cmd1En), .addrEn(addrEn), .addrCnt(addrCnt),
    .cmd2En(cmd2En), .dirWrite(dirWrite), .countZero(countZero), .countOne(countOne),
    .strobe(strobe), .cle(cle), .ale(ale), .weN(weN), .reN(reN), .ioOe(ioOe),
    .wrTake(wrTake), .busy(busy), .done(done)
  );

  nandSeqPath u_path (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .busy(busy),
    .strobe(strobe), .cmd1Code(cmd1Code), .cmd2Code(cmd2Code), .addrWord(addrWord),
    .wrData(wrData), .ioIn(ioIn), .cfgRdData(cfgRdData), .cmd1En(cmd1En),
    .addrEn(addrEn), .addrCnt(addrCnt), .cmd2En(cmd2En), .dirWrite(dirWrite),
    .countZero(countZero), .countOne(countOne), .ioOut(ioOut), .rdData(rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/nandSeqChk.sv
module nandSeqChk
  import nandSeqPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [31:0] cfgRdData,
  input logic        cle,
  input logic        ale,
  input logic        weN,
  input logic        reN,
  input logic        ioOe,
  input logic        busy,
  input logic        done
);

  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !reN));
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rstN) !weN |=> weN);
  p_re_pulse_r7: assert property (@(posedge clk) disable iff (!rstN) !reN |=> reN);
  p_latch_drive_r5: assert property (@(posedge clk) disable iff (!rstN) (cle || ale) |-> ioOe);
  p_done_once_r10: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rstN) done |-> busy);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~CFG_MASK) == '0);

endmodule

bind nandSeqTop nandSeqChk u_chk (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .cle(cle), .ale(ale),
  .weN(weN), .reN(reN), .ioOe(ioOe), .busy(busy), .done(done)
);

// File: tb/tb_nandSeqTop.sv
`timescale 1ns/1ps
module tb_nandSeqTop;

  localparam int SECT = 512;
  localparam logic [31:0] MASK = 32'hFFFF_003F;
  localparam int K_CMD = 0, K_ADDR = 1, K_WAIT = 2, K_RD = 3, K_WR = 4, K_DONE = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, sectorMode = 1'b0, start = 1'b0, flashReady = 1'b1;
  logic [31:0] cfgWrData = '0, addrWord = 32'h4433_2211;
  logic [7:0]  cmd1Code = 8'h5A, cmd2Code = 8'hC3, wrData = 8'h00, ioIn = 8'h17;
  logic [31:0] cfgRdData;
  logic [7:0]  rdData, ioOut;
  logic wrTake, rdValid, ioOe, cle, ale, weN, reN, busy, done;

  int checks = 0, fails = 0, doneCnt = 0;

  always #5 clk = ~clk;

  nandSeqTop dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .sectorMode(sectorMode), .start(start), .cmd1Code(cmd1Code), .cmd2Code(cmd2Code),
    .addrWord(addrWord), .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .flashReady(flashReady), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .busy(busy), .done(done)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int q[$];
  int ph = 0;
  logic [31:0] mCfg = '0;
  logic [7:0]  expRd = '0;

  function automatic int item(int k, int last, int b);
    return (k << 12) | (last << 8) | (b & 255);
  endfunction

  task automatic buildQueue();
    int cnt;
    if (!sectorMode) mCfg[31:16] = 16'd1;
    cnt = mCfg[31:16];
    if (mCfg[0]) q.push_back(item(K_CMD, 0, cmd1Code));
    if (mCfg[1])
      for (int i = 0; i <= int'(mCfg[3:2]); i++) q.push_back(item(K_ADDR, 0, addrWord[8*i +: 8]));
    if (mCfg[4]) q.push_back(item(K_CMD, 0, cmd2Code));
    for (int s = 0; s < cnt; s++) begin
      if ((s == 0 && mCfg[4]) || sectorMode) q.push_back(item(K_WAIT, 0, 0));
      for (int b = 0; b < SECT; b++)
        q.push_back(item(mCfg[5] ? K_WR : K_RD, (b == SECT-1) ? 1 : 0, 0));
    end
    q.push_back(item(K_DONE, 0, 0));
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); ph = 0; mCfg = '0;
    end else if (q.size() == 0) begin
      if (cfgWrEn) mCfg = cfgWrData & MASK;
      if (start) buildQueue();
    end else begin
      int k;
      k = q[0] >> 12;
      if (k == K_RD && ph == 0) expRd = ioIn;
      if (k == K_WAIT) begin
        if (flashReady) void'(q.pop_front());
      end else if (k == K_DONE) begin
        void'(q.pop_front());
      end else if (ph == 0) begin
        ph = 1;
      end else begin
        ph = 0;
        if (((q[0] >> 8) & 1) == 1) mCfg[31:16] = mCfg[31:16] - 16'd1;
        void'(q.pop_front());
      end
    end
  end

  // cycle compare, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      int k;
      logic eBusy, eDone, eCle, eAle, eWeN, eReN, eOe, eTake, eVal;
      k = (q.size() == 0) ? -1 : (q[0] >> 12);
      eBusy = (k >= 0);
      eDone = (k == K_DONE);
      eCle  = (k == K_CMD);
      eAle  = (k == K_ADDR);
      eOe   = (k == K_CMD || k == K_ADDR || k == K_WR);
      eWeN  = !(eOe && ph == 0);
      eReN  = !(k == K_RD && ph == 0);
      eTake = (k == K_WR && ph == 1);
      eVal  = (k == K_RD && ph == 1);
      if (done) doneCnt++;
      check(busy == eBusy, "R10", "busy", busy, eBusy);
      check(done == eDone, "R10", "done", done, eDone);
      check(cle == eCle, "R5", "cle", cle, eCle);
      check(ale == eAle, "R5", "ale", ale, eAle);
      check(weN == eWeN, "R5", "weN", weN, eWeN);
      check(ioOe == eOe, "R5", "ioOe", ioOe, eOe);
      check(reN == eReN, "R7", "reN", reN, eReN);
      check(wrTake == eTake, "R7", "wrTake", wrTake, eTake);
      check(rdValid == eVal, "R7", "rdValid", rdValid, eVal);
      if (eVal) check(rdData == expRd, "R7", "rdData", rdData, expRd);
      if (k == K_CMD || k == K_ADDR)
        check(ioOut == q[0][7:0], "R4", "ioOut byte", ioOut, q[0][7:0]);
      if (k == K_WR) check(ioOut == wrData, "R7", "ioOut write", ioOut, wrData);
      check(cfgRdData == mCfg, "R8", "cfgRdData", cfgRdData, mCfg);
    end
  end

  always @(negedge clk) begin
    ioIn   <= ioIn * 8'd5 + 8'd3;
    wrData <= wrData + 8'd7;
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mkCfg(int cnt, bit dir, bit c2, int acnt, bit aen, bit c1);
    return {cnt[15:0], 10'b0, dir, c2, acnt[1:0], aen, c1};
  endfunction

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic pulseStart(input logic mode);
    @(negedge clk); sectorMode = mode; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitIdle();
    do @(posedge clk); while (q.size() != 0 || busy);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cfgRdData == 0 && weN && reN && !cle && !ale && !ioOe && !busy && !done,
          "R1", "reset state", {weN, reN, cle, ale, ioOe, busy, done}, 7'b1100000);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reserved bits read zero
    writeCfg(32'hFFFF_FFFF);
    @(negedge clk);
    check(cfgRdData == MASK, "R2", "reserved readback", cfgRdData, MASK);

    // command mode: all stages, 4 addr bytes, read; ready low 20 cycles (R6, R9)
    writeCfg(mkCfg(5, 0, 1, 3, 1, 1));
    flashReady = 1'b0;
    pulseStart(1'b0);
    check(cfgRdData[31:16] == 16'd1, "R9", "count forced", cfgRdData[31:16], 1);
    repeat (20) @(negedge clk);
    check(busy && reN, "R6", "held while not ready", {busy, reN}, 2'b11);
    flashReady = 1'b1;
    waitIdle();
    check(cfgRdData[31:16] == 16'd0, "R9", "count after one sector", cfgRdData[31:16], 0);

    // R3/R4: no opening command, 2 addr bytes, write, no wait
    writeCfg(mkCfg(0, 1, 0, 1, 1, 0));
    @(negedge clk); sectorMode = 1'b0; start = 1'b1;
    @(posedge clk); #2;
    check(ale == 1'b1, "R3", "address stage first cycle", ale, 1);
    @(negedge clk); start = 1'b0;
    // R10: start and cfg write while busy are ignored
    repeat (10) @(negedge clk);
    start = 1'b1; cfgWrEn = 1'b1; cfgWrData = 32'h0000_0001;
    @(negedge clk); start = 1'b0; cfgWrEn = 1'b0;
    doneCnt = 0;
    waitIdle();
    check(doneCnt == 1, "R10", "single done", doneCnt, 1);
    check(cfgRdData[5:0] == 6'h26, "R2", "write ignored while busy", cfgRdData[5:0], 6'h26);

    // R8: sector mode, 3 sectors, read, ready toggling
    writeCfg(mkCfg(3, 0, 1, 0, 1, 1));
    fork
      begin pulseStart(1'b1); waitIdle(); end
      begin
        for (int i = 0; i < 3500; i++) begin
          @(negedge clk); flashReady = (i % 9) > 3;
        end
        flashReady = 1'b1;
      end
    join_any
    waitIdle();
    flashReady = 1'b1;
    check(cfgRdData[31:16] == 0, "R8", "count after sectors", cfgRdData[31:16], 0);

    // R8: sector mode, count 0 -> no data stage
    writeCfg(mkCfg(0, 0, 0, 0, 0, 0));
    pulseStart(1'b1);
    check(done == 1'b1 && reN, "R8", "zero count done", {done, reN}, 2'b11);
    waitIdle();

    // sector mode write, 2 sectors, no command stages
    writeCfg(mkCfg(2, 1, 0, 2, 1, 0));
    pulseStart(1'b1);
    waitIdle();
    check(cfgRdData[31:16] == 0, "R8", "write sectors count", cfgRdData[31:16], 0);

    // command mode, data only
    writeCfg(mkCfg(0, 1, 0, 0, 0, 0));
    pulseStart(1'b0);
    waitIdle();
    check(cfgRdData[31:16] == 0, "R9", "data only count", cfgRdData[31:16], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule